// File: doc/BRIEF.md
# I2C Master Bus-Condition Sequencer

This block drives the bus conditions that a controller needs between bytes: a repeated start, a stop, and a stop followed directly by a new start. It drives SCL and SDA through open-drain pull-low enables. Every phase lasts a fixed half-bit period, which is counted in cycles of an oversampling clock. A mode input selects either the short half-bit or the long one, and the block latches that choice when it accepts a command.

The sequencer assumes that SCL is low when it receives a command, as it is just after the acknowledge bit. Each phase that releases SCL starts its count only once the synchronized SCL line reads high. A slave that stretches the clock therefore lengthens that phase. Separately from the sequencer, both raw bus lines pass through two-flop synchronizers. A small detector flags a start or stop condition on the bus, whoever produced it.

Top module: `i2c_cond_seq`

## Requirements
- R1: While reset is active and on the first cycle after it, scl_low_o, sda_low_o, busy_o, done_o, start_det_o and stop_det_o are all 0, so both lines are released.
- R2: One half-bit H is 8 clocks when wide_i=0 and 16 clocks when wide_i=1. The block samples wide_i only on the accept cycle, and a later change has no effect on a sequence already running.
- R3: The block accepts a command when cmd_valid_i=1, it is idle, and cmd_i is not 2'b00. The codes are 2'b01 for a repeated start, 2'b10 for a stop and 2'b11 for a stop followed by a start. With cmd_i=2'b00 the block stays idle. busy_o is 1 from the cycle after accept until the final phase ends.
- R4: A command presented while busy_o=1 is ignored: the running sequence keeps its length and the block returns to idle afterwards.
- R5: A repeated start runs four phases, where "low" means the drive output is 1. First SCL is low and SDA released for H cycles. Then both lines are released until the synchronized SCL reads high, followed by H more cycles. Then SDA is low and SCL released for H cycles. Finally both are low for H cycles. Without stretching, busy_o lasts 4H+2 cycles.
- R6: A stop runs three phases. First both lines are low for H cycles. Then SCL is released with SDA still low, until synchronized SCL reads high, followed by H more cycles. Finally both are released for H cycles. Without stretching, busy_o lasts 3H+2 cycles.
- R7: A stop followed by a start runs the three stop phases and then, without going idle, the last two repeated-start phases. Without stretching, busy_o lasts 5H+2 cycles.
- R8: If the bus holds SCL low after the block releases it, the phase waits; each extra low cycle adds one cycle to busy_o.
- R9: done_o is a single-cycle pulse on the first idle cycle after the final phase.
- R10: start_det_o pulses for one cycle when synchronized SDA falls while synchronized SCL is high; stop_det_o pulses when it rises under the same condition. The pulse appears 3 cycles after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code (01 restart, 10 stop, 11 stop+start) |
| wide_i | input | 1 | Half-bit select: 0 gives 8 clocks, 1 gives 16 clocks |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| start_det_o | output | 1 | Start condition seen on the bus |
| stop_det_o | output | 1 | Stop condition seen on the bus |

## Verification
The assertions check several properties on every cycle:
- the half-bit counter stays in range;
- a wait phase cannot advance while synchronized SCL is low;
- SDA changes with SCL released only in the phases that form a start or a stop;
- done and the detector outputs are single-cycle pulses, and the block never leaves idle without an accepted command.

Other behaviours need the bench's scenarios:
- the exact phase lengths for each command and each mode;
- stretch-extended timing;
- commands ignored while busy;
- the mode latched at accept;
- start and stop detection caused by an external master.

The bench shows these by comparing every cycle against its reference model and by measuring busy lengths.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef enum logic [1:0] {
    CMD_NONE       = 2'b00,
    CMD_RESTART    = 2'b01,
    CMD_STOP       = 2'b10,
    CMD_STOP_START = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RS_LOW,
    ST_RS_HIGH,
    ST_RS_FALL,
    ST_RS_HOLD,
    ST_SP_LOW,
    ST_SP_HIGH,
    ST_SP_FREE
  } state_e;
endpackage

// File: rtl/i2c_cond_sync.sv
module i2c_cond_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o
);
  logic sda_q, start_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q   <= 1'b1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      sda_q   <= sda_s_i;
      start_q <= scl_s_i && sda_q && !sda_s_i;
      stop_q  <= scl_s_i && !sda_q && sda_s_i;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;

  // R10: a start or stop indication never lasts two cycles
  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_stop_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
endmodule

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer #(
  parameter int HALF_LO = 8,
  parameter int HALF_HI = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic wide_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(HALF_HI);

  logic             wide_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = wide_q ? CNT_W'(HALF_HI - 1) : CNT_W'(HALF_LO - 1);
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      wide_q <= wide_i;
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q  <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: count never passes the selected half-bit
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  // R2: mode is frozen outside of accept
  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> wide_q == $past(wide_q));
endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
  import i2c_cond_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       scl_high_i,
  input  logic       tick_i,
  output logic       load_o,
  output logic       run_o,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       busy_o,
  output logic       done_o
);
  state_e st_q, st_nxt;
  logic   chain_q, done_q, wait_ph;

  assign load_o  = cmd_valid_i && (st_q == ST_IDLE) && (cmd_e'(cmd_i) != CMD_NONE);
  assign wait_ph = (st_q == ST_RS_HIGH) || (st_q == ST_SP_HIGH);
  assign run_o   = (st_q != ST_IDLE) && (!wait_ph || scl_high_i);

  always_comb begin
    unique case (st_q)
      ST_RS_LOW:  st_nxt = ST_RS_HIGH;
      ST_RS_HIGH: st_nxt = ST_RS_FALL;
      ST_RS_FALL: st_nxt = ST_RS_HOLD;
      ST_SP_LOW:  st_nxt = ST_SP_HIGH;
      ST_SP_HIGH: st_nxt = ST_SP_FREE;
      ST_SP_FREE: st_nxt = chain_q ? ST_RS_FALL : ST_IDLE;
      default:    st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      chain_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        st_q    <= (cmd_e'(cmd_i) == CMD_RESTART) ? ST_RS_LOW : ST_SP_LOW;
        chain_q <= (cmd_e'(cmd_i) == CMD_STOP_START);
      end else if (tick_i) begin
        st_q   <= st_nxt;
        done_q <= (st_nxt == ST_IDLE);
      end
    end
  end

  assign scl_low_o = (st_q == ST_RS_LOW) || (st_q == ST_RS_HOLD) || (st_q == ST_SP_LOW);
  assign sda_low_o = (st_q == ST_RS_FALL) || (st_q == ST_RS_HOLD) ||
                     (st_q == ST_SP_LOW)  || (st_q == ST_SP_HIGH);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_q == ST_IDLE) && ($past(st_q) != ST_IDLE));
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !load_o) |=> st_q == ST_IDLE);
  p_stretch_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_ph && !scl_high_i) |=> st_q == $past(st_q));
  // R5/R6: SDA moves under a released SCL only to form a start or a stop
  p_sda_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_low_o && !$past(scl_low_o) && (sda_low_o != $past(sda_low_o)))
      |-> (st_q == ST_RS_FALL || st_q == ST_SP_FREE));
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int HALF_LO     = 8,
  parameter int HALF_HI     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       wide_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       start_det_o,
  output logic       stop_det_o
);
  logic scl_s, sda_s, load, run, tick;

  i2c_cond_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  i2c_cond_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  i2c_cond_det u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(start_det_o), .stop_o(stop_det_o));

  i2c_cond_timer #(.HALF_LO(HALF_LO), .HALF_HI(HALF_HI)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .wide_i(wide_i),
    .run_i(run), .tick_o(tick));

  i2c_cond_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .scl_high_i(scl_s), .tick_i(tick), .load_o(load), .run_o(run),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o),
    .done_o(done_o));
endmodule

// File: tb/i2c_cond_seq_tb.sv
module i2c_cond_seq_tb;
  // 4 time units per clock: 250 MHz at 1 ns per unit
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       wide = 1'b0, ext_scl = 1'b0, ext_sda = 1'b0;
  logic       scl_drv, sda_drv, busy, done, sdet, pdet;
  logic       scl_pin, sda_pin;

  assign scl_pin = !(scl_drv || ext_scl);
  assign sda_pin = !(sda_drv || ext_sda);

  i2c_cond_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wide_i(wide), .scl_i(scl_pin), .sda_i(sda_pin),
    .scl_low_o(scl_drv), .sda_low_o(sda_drv), .busy_o(busy), .done_o(done),
    .start_det_o(sdet), .stop_det_o(pdet));

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: phase codes bit0 scl low, bit1 sda low, bit2 waits for SCL high
  int ph_q[$];
  int scl_h[$], sda_h[$];
  int m_half = 8, m_cnt = 0;
  bit m_done = 0, m_sdet = 0, m_pdet = 0;

  task automatic model_reset();
    ph_q.delete(); scl_h.delete(); sda_h.delete();
    for (int i = 0; i < 6; i++) begin scl_h.push_back(1); sda_h.push_back(1); end
    m_cnt = 0; m_done = 0; m_sdet = 0; m_pdet = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int es, ed;
      bit nd, gate;
      es = (ph_q.size() != 0) ? (ph_q[0] & 1) : 0;
      ed = (ph_q.size() != 0) ? ((ph_q[0] >> 1) & 1) : 0;
      chk(tag, "scl_low", int'(scl_drv), es);
      chk(tag, "sda_low", int'(sda_drv), ed);
      chk("R3", "busy", int'(busy), int'(ph_q.size() != 0));
      chk("R9", "done", int'(done), int'(m_done));
      chk("R10", "start_det", int'(sdet), int'(m_sdet));
      chk("R10", "stop_det", int'(pdet), int'(m_pdet));
      scl_h.push_front(int'(scl_pin)); sda_h.push_front(int'(sda_pin));
      void'(scl_h.pop_back()); void'(sda_h.pop_back());
      m_sdet = (scl_h[2] == 1) && (sda_h[3] == 1) && (sda_h[2] == 0);
      m_pdet = (scl_h[2] == 1) && (sda_h[3] == 0) && (sda_h[2] == 1);
      nd = 0;
      if (ph_q.size() == 0) begin
        if (cmd_valid && cmd != 2'b00) begin
          m_half = wide ? 16 : 8; m_cnt = 0;
          if (cmd == 2'b01) ph_q = '{1, 4, 2, 3};
          else if (cmd == 2'b10) ph_q = '{3, 6, 0};
          else ph_q = '{3, 6, 0, 2, 3};
        end
      end else begin
        gate = ((ph_q[0] & 4) != 0) ? (scl_h[2] == 1) : 1'b1;
        if (gate) begin
          if (m_cnt == m_half - 1) begin
            void'(ph_q.pop_front()); m_cnt = 0;
            nd = (ph_q.size() == 0);
          end else m_cnt++;
        end
      end
      m_done = nd;
    end
  end

  task automatic run_cmd(input logic [1:0] c, input bit w, input int stretch, output int len);
    int h;
    h = w ? 16 : 8;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd = c; wide = w;
    if (stretch > 0) begin
      ext_scl = 1'b1;
      fork
        begin repeat (h + 1 + stretch) @(posedge clk); #1 ext_scl = 1'b0; end
      join_none
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    len = 0;
    while (1) begin
      @(negedge clk);
      if (!busy) break;
      len++;
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int len, cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "scl_low in reset", int'(scl_drv), 0);
    chk("R1", "sda_low in reset", int'(sda_drv), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "det after reset", int'(sdet | pdet), 0);

    tag = "R5"; run_cmd(2'b01, 1'b0, 0, len); chk("R5", "restart len H=8", len, 34);
    tag = "R2"; run_cmd(2'b01, 1'b1, 0, len); chk("R2", "restart len H=16", len, 66);
    tag = "R6"; run_cmd(2'b10, 1'b0, 0, len); chk("R6", "stop len H=8", len, 26);
    run_cmd(2'b10, 1'b1, 0, len); chk("R6", "stop len H=16", len, 50);
    tag = "R7"; run_cmd(2'b11, 1'b1, 0, len); chk("R7", "stop+start len H=16", len, 82);
    run_cmd(2'b11, 1'b0, 0, len); chk("R7", "stop+start len H=8", len, 42);
    tag = "R8"; run_cmd(2'b10, 1'b0, 5, len); chk("R8", "stretched stop len", len, 31);
    run_cmd(2'b01, 1'b1, 9, len); chk("R8", "stretched restart len", len, 75);

    // R3: code 00 does nothing
    tag = "R3";
    @(posedge clk); #1 cmd_valid = 1'b1; cmd = 2'b00;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk); chk("R3", "busy after code 00", int'(busy), 0);

    // R2: wide_i change after accept is ignored
    tag = "R2";
    fork
      begin @(posedge clk); @(posedge clk); #2 wide = 1'b0; end
    join_none
    run_cmd(2'b01, 1'b1, 0, len); chk("R2", "mode latched len", len, 66);

    // R4: command during busy ignored
    tag = "R4";
    fork
      begin
        repeat (6) @(posedge clk); #1 cmd_valid = 1'b1; cmd = 2'b10;
        @(posedge clk); #1 cmd_valid = 1'b0;
      end
    join_none
    run_cmd(2'b01, 1'b0, 0, len); chk("R4", "len with mid command", len, 34);
    @(negedge clk); chk("R4", "idle after sequence", int'(busy), 0);

    // R10: external master start and stop on idle bus
    tag = "R10";
    @(posedge clk); #1 ext_sda = 1'b1;
    cnt = 0;
    repeat (6) begin @(negedge clk); cnt += int'(sdet); end
    chk("R10", "external start pulses", cnt, 1);
    @(posedge clk); #1 ext_sda = 1'b0;
    cnt = 0;
    repeat (6) begin @(negedge clk); cnt += int'(pdet); end
    chk("R10", "external stop pulses", cnt, 1);

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule